// File: doc/BRIEF.md
# Text Cursor Blink and Skew Unit

This block sits beside a raster timing generator and produces a single cursor signal. On every character clock it compares the memory address being fetched with a programmed cursor address. When they match, it raises the cursor on the scan lines of that character cell that lie between a programmed first and last raster. The result is gated by display enable, masked by a blink control that follows a frame counter, and then delayed by zero, one or two character clocks, or suppressed, so that it lines up with a display-enable signal that has been skewed the same way.

Software programs the unit through a small write port that takes a register number and a data byte. The cursor address is split across a high byte and a low byte. The raster limits, the blink mode and the skew code each sit in their own register fields. Each clock edge is one character time. The frame strobe is a one-cycle pulse per vertical sync. No data stream passes through the block, so it has no valid/ready handshake. All of its pins are plain control and status signals.

Top module: `txt_cursor_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the cursor output is low. All programmed fields are cleared: cursor address 0, first and last raster 0, steady blink mode, skew code 00. The frame counter is zero.
- R2: A write with `wr_en_i` high stores the field on the clock edge. It affects inputs sampled from the next edge on. Register 8 bits 7..6 hold the skew code. Register 10 bits 4..0 hold the first raster, bit 5 the blink rate and bit 6 the blink enable. Register 11 bits 4..0 hold the last raster. Register 14 holds the upper address bits (bits ADDR_W-9..0 of the byte). Register 15 holds address bits 7..0. A write to any other register number changes nothing.
- R3: The undelayed cursor is high only when `ma_i` equals the cursor address and the first raster <= `ra_i` <= the last raster. If the first raster exceeds the last raster, the cursor never shows.
- R4: With `de_i` low, the cursor is not produced for that character.
- R5: Blink bits {enable,rate} = 00 shows the cursor steadily.
- R6: Blink bits {enable,rate} = 01 keeps the cursor off.
- R7: Blink bits 10 (fast) show the cursor while bit 3 of the frame count is 0. The frame count is the number of `frame_stb_i` pulses since reset, modulo 32.
- R8: Blink bits 11 (slow) show the cursor while bit 4 of the frame count is 0.
- R9: Skew code 00 gives the cursor one edge after the inputs are sampled. Code 01 gives it two edges after, and code 10 three edges after. A change of skew code takes effect on the output straight after the write edge.
- R10: Skew code 11 holds the cursor output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ma_i | input | ADDR_W | Memory address of the current character |
| ra_i | input | RA_W | Current scan line within the character row |
| de_i | input | 1 | Display enable, undelayed |
| frame_stb_i | input | 1 | One-cycle pulse per frame (vertical sync) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 5 | Register number |
| wr_data_i | input | 8 | Register write data |
| cursor_o | output | 1 | Blinked, skewed cursor signal |

## Verification
A cursor condition sampled at an edge reaches `cursor_o` one, two or three edges later, for skew codes 00, 01 and 10. A write is visible to inputs sampled from the following edge on, and a frame pulse changes the blink phase for the next sampled character. The bench keeps a behavioural model that applies the same ordering: it evaluates the condition with the field values before the edge, then applies writes and frame pulses, then pushes the result into a history queue indexed by the current skew. The bench compares that model with the output at every falling edge, where the output is stable.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  // {blink enable, blink rate} as written into bits 6..5 of the start register
  typedef enum logic [1:0] {
    BLK_STEADY = 2'b00,
    BLK_OFF    = 2'b01,
    BLK_FAST   = 2'b10,
    BLK_SLOW   = 2'b11
  } blink_e;

  localparam logic [4:0] SEL_SKEW     = 5'd8;
  localparam logic [4:0] SEL_CSTART   = 5'd10;
  localparam logic [4:0] SEL_CEND     = 5'd11;
  localparam logic [4:0] SEL_CADDR_HI = 5'd14;
  localparam logic [4:0] SEL_CADDR_LO = 5'd15;

  localparam logic [1:0] SKEW_OFF = 2'b11;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_sel_i,
  input  logic [7:0]        wr_data_i,
  output logic [1:0]        skew_o,
  output logic [RA_W-1:0]   start_o,
  output logic [RA_W-1:0]   end_o,
  output blink_e            mode_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skew_o  <= 2'b00;
      start_o <= '0;
      end_o   <= '0;
      mode_o  <= BLK_STEADY;
      addr_o  <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_SKEW:     skew_o <= wr_data_i[7:6];
        SEL_CSTART: begin
          start_o <= wr_data_i[RA_W-1:0];
          mode_o  <= blink_e'(wr_data_i[6:5]);
        end
        SEL_CEND:     end_o <= wr_data_i[RA_W-1:0];
        SEL_CADDR_HI: addr_o[ADDR_W-1:8] <= wr_data_i[HI_W-1:0];
        SEL_CADDR_LO: addr_o[7:0] <= wr_data_i;
        default: ;
      endcase
    end
  end

  logic known_sel;
  assign known_sel = (wr_sel_i == SEL_SKEW) || (wr_sel_i == SEL_CSTART) ||
                     (wr_sel_i == SEL_CEND) || (wr_sel_i == SEL_CADDR_HI) ||
                     (wr_sel_i == SEL_CADDR_LO);

  // R2
  unused_sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !known_sel) |=> ($stable(skew_o) && $stable(start_o) &&
                                 $stable(end_o) && $stable(mode_o) && $stable(addr_o)));
endmodule

// File: rtl/cursor_blink.sv
module cursor_blink
  import cursor_pkg::*;
#(
  parameter int FAST_LOG2 = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_stb_i,
  input  blink_e mode_i,
  output logic   show_o
);
  localparam int CNT_W = FAST_LOG2 + 2;

  logic [CNT_W-1:0] frame_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           frame_cnt <= '0;
    else if (frame_stb_i) frame_cnt <= frame_cnt + 1'b1;
  end

  always_comb begin
    case (mode_i)
      BLK_STEADY: show_o = 1'b1;
      BLK_OFF:    show_o = 1'b0;
      BLK_FAST:   show_o = !frame_cnt[FAST_LOG2];
      BLK_SLOW:   show_o = !frame_cnt[FAST_LOG2+1];
      default:    show_o = 1'b0;
    endcase
  end

  // R7
  frame_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_i |=> (frame_cnt == $past(frame_cnt) + 1'b1));
  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb_i |=> $stable(frame_cnt));
endmodule

// File: rtl/cursor_skew.sv
module cursor_skew
  import cursor_pkg::*;
#(
  parameter int MAX_SKEW = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       d_i,
  input  logic [1:0] sel_i,
  output logic       q_o
);
  logic [MAX_SKEW:0] tap;
  logic [MAX_SKEW:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap <= '0;
    else        tap <= {tap[MAX_SKEW-1:0], d_i};
  end

  for (genvar i = 0; i <= MAX_SKEW; i++) begin : g_pick
    assign hit[i] = (sel_i == 2'(i)) && tap[i];
  end

  assign q_o = (sel_i != SKEW_OFF) && (|hit);
endmodule

// File: rtl/txt_cursor_unit.sv
module txt_cursor_unit
  import cursor_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int RA_W      = 5,
  parameter int FAST_LOG2 = 3,
  parameter int MAX_SKEW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ma_i,
  input  logic [RA_W-1:0]   ra_i,
  input  logic              de_i,
  input  logic              frame_stb_i,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_sel_i,
  input  logic [7:0]        wr_data_i,
  output logic              cursor_o
);
  logic [1:0]        skew_q;
  logic [RA_W-1:0]   start_q;
  logic [RA_W-1:0]   end_q;
  blink_e            mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              show;
  logic              raw_cursor;

  cursor_regs #(.ADDR_W(ADDR_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .skew_o(skew_q), .start_o(start_q), .end_o(end_q),
    .mode_o(mode_q), .addr_o(addr_q)
  );

  cursor_blink #(.FAST_LOG2(FAST_LOG2)) u_blink (
    .clk(clk), .rst_n(rst_n), .frame_stb_i(frame_stb_i), .mode_i(mode_q),
    .show_o(show)
  );

  // gate with display enable before the delay line
  assign raw_cursor = de_i && show && (ma_i == addr_q) &&
                      (ra_i >= start_q) && (ra_i <= end_q);

  cursor_skew #(.MAX_SKEW(MAX_SKEW)) u_skew (
    .clk(clk), .rst_n(rst_n), .d_i(raw_cursor), .sel_i(skew_q), .q_o(cursor_o)
  );

  // R3
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ma_i != addr_q) |=> (skew_q != 2'b00 || !cursor_o));
  // R4
  de_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de_i |=> (skew_q != 2'b00 || !cursor_o));
  // R6
  blink_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BLK_OFF) |=> (skew_q != 2'b00 || !cursor_o));
  // R10
  skew_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skew_q == SKEW_OFF) |-> !cursor_o);
endmodule

// File: tb/txt_cursor_unit_tb.sv
module txt_cursor_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ma_r = '0;
  logic [4:0]  ra_r = '0;
  logic        de_r = 1'b0;
  logic        fs_r = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        cursor_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  txt_cursor_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ma_i(ma_r), .ra_i(ra_r), .de_i(de_r),
    .frame_stb_i(fs_r), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .cursor_o(cursor_o)
  );

  // behavioural reference model
  int m_addr, m_start, m_end, m_mode, m_skew, m_cnt;
  bit hist[$];
  bit exp_cur = 0;

  always @(posedge clk) begin
    bit show, raw;
    if (!rst_n) begin
      m_addr = 0; m_start = 0; m_end = 0; m_mode = 0; m_skew = 0; m_cnt = 0;
      hist = '{0, 0, 0};
      exp_cur = 0;
    end else begin
      case (m_mode)
        0: show = 1;
        1: show = 0;
        2: show = ((m_cnt / 8) % 2) == 0;
        default: show = ((m_cnt / 16) % 2) == 0;
      endcase
      raw = de_r && show && (int'(ma_r) == m_addr) &&
            (int'(ra_r) >= m_start) && (int'(ra_r) <= m_end);
      hist.push_front(raw);
      void'(hist.pop_back());
      if (wr_en) begin
        case (wr_sel)
          5'd8:  m_skew = wr_data / 64;
          5'd10: begin m_start = wr_data % 32; m_mode = (wr_data / 32) % 4; end
          5'd11: m_end = wr_data % 32;
          5'd14: m_addr = (m_addr % 256) + (wr_data % 64) * 256;
          5'd15: m_addr = (m_addr / 256) * 256 + wr_data;
          default: ;
        endcase
      end
      if (fs_r) m_cnt = (m_cnt + 1) % 32;
      exp_cur = (m_skew == 3) ? 1'b0 : hist[m_skew];
    end
  end

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: cursor_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !done) check(cur_req, cursor_o, exp_cur);

  task automatic step(input logic [13:0] ma, input logic [4:0] ra, input bit de, input bit fs);
    ma_r = ma; ra_r = ra; de_r = de; fs_r = fs;
    @(negedge clk);
  endtask

  task automatic wreg(input logic [4:0] sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sweep(input int n, input bit rand_de);
    for (int k = 0; k < n; k++) begin
      logic [13:0] a;
      a = ($urandom % 3 != 0) ? 14'h0123 : 14'($urandom);
      step(a, 5'($urandom % 8), rand_de ? 1'($urandom) : 1'b1, 1'b0);
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: output low while in reset, even with a matching default address
    ma_r = '0; ra_r = '0; de_r = 1'b1;
    @(negedge clk);
    check("R1", cursor_o, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1;
    cur_req = "R1";
    step(14'h0000, 5'd0, 1'b1, 1'b0);
    step(14'h0000, 5'd0, 1'b1, 1'b0);
    cur_req = "R2";
    wreg(5'd15, 8'h23);
    wreg(5'd14, 8'hC1);   // only low 6 bits kept: address 0x123
    wreg(5'd10, 8'h02);   // steady, first raster 2
    wreg(5'd11, 8'h05);
    cur_req = "R3"; sweep(200, 1'b0);
    cur_req = "R5"; sweep(40, 1'b0);
    cur_req = "R4"; sweep(150, 1'b1);
    cur_req = "R2";
    wreg(5'd9, 8'hFF); wreg(5'd12, 8'hFF); wreg(5'd13, 8'hFF);
    wreg(5'd16, 8'hFF); wreg(5'd31, 8'hFF); wreg(5'd0, 8'hFF);
    sweep(60, 1'b0);
    cur_req = "R3";
    wreg(5'd10, 8'h06); wreg(5'd11, 8'h03);   // start > end
    sweep(60, 1'b0);
    wreg(5'd10, 8'h02); wreg(5'd11, 8'h05);
    cur_req = "R6";
    wreg(5'd10, 8'h22);
    sweep(60, 1'b0);
    cur_req = "R7";
    wreg(5'd10, 8'h42);
    for (int f = 0; f < 40; f++) begin
      step(14'h0123, 5'd3, 1'b1, 1'b1);
      for (int k = 0; k < 4; k++) step(14'h0123, 5'($urandom % 8), 1'b1, 1'b0);
    end
    cur_req = "R8";
    wreg(5'd10, 8'h62);
    for (int f = 0; f < 70; f++) begin
      step(14'h0123, 5'd4, 1'b1, 1'b1);
      for (int k = 0; k < 3; k++) step(14'h0123, 5'($urandom % 8), 1'b1, 1'b0);
    end
    wreg(5'd10, 8'h02);
    cur_req = "R9";
    wreg(5'd8, 8'h40); sweep(150, 1'b1);
    wreg(5'd8, 8'h80); sweep(150, 1'b1);
    wreg(5'd8, 8'h00); sweep(60, 1'b1);
    // isolated pulse under two-character skew, switched mid-stream
    wreg(5'd8, 8'h80);
    step(14'h0123, 5'd3, 1'b1, 1'b0);
    step(14'h0000, 5'd3, 1'b1, 1'b0);
    step(14'h0000, 5'd3, 1'b1, 1'b0);
    step(14'h0000, 5'd3, 1'b1, 1'b0);
    cur_req = "R10";
    wreg(5'd8, 8'hC0); sweep(100, 1'b1);
    wreg(5'd8, 8'hFF); sweep(40, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule